// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit device-side virtual address into a physical address by reading descriptors from a two-level table in memory. A client presents one request at a time, carrying the address and a flag saying whether the access is a write. The walker reads one first-level descriptor and, if that descriptor points to a second-level table, one more. It then returns either a physical address of up to 36 bits or a fault code, together with the virtual address of the request. No result is cached, so every request causes a fresh walk.

Descriptors are 32 bits wide. A static mode input selects narrow operation, where descriptor values are used as they are and addresses are 32 bits, or wide operation. In wide operation every descriptor value is shifted left by four before it is masked, the table base input holds a 4 KiB frame number, and permission fields in the leaf descriptors are enforced. Leaves may map 1 MiB sections, 64 KiB large pages or 4 KiB small pages.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_rd_valid are 0.
- R2: The first read of a walk goes to T + 4*va[31:20]. T is tbl_base zero-extended when wide_mode is 0, and tbl_base shifted left by 12 when wide_mode is 1.
- R3: A first-level descriptor with bits [1:0] = 2 is a 1 MiB section. The walk ends after one read with rsp_fault = 0 and rsp_pa = ((desc << s) with bits [19:0] cleared) | va[19:0], where s is 4 in wide mode and 0 otherwise.
- R4: A first-level descriptor with bits [1:0] = 1 starts a second read at ((desc with bits [5:0] cleared) << s) + 4*va[19:12].
- R5: A first-level descriptor with bits [1:0] equal to 0 or 3 ends the walk after one read with rsp_fault = 1 (translation fault).
- R6: In a second-level descriptor, bit 1 set marks a 4 KiB page and rsp_pa = ((desc << s) with bits [11:0] cleared) | va[11:0]. Bits [1:0] = 1 mark a 64 KiB page and rsp_pa = ((desc << s) with bits [15:0] cleared) | va[15:0]. Bits [1:0] = 0 give rsp_fault = 1.
- R7: In wide mode the permission field is bits [5:4] of a section descriptor and bits [3:2] of a page descriptor. Value 0 allows nothing, 1 allows reads only, 2 allows writes only and 3 allows both. A disallowed access gives rsp_fault = 2 (protection fault). In narrow mode no permission is checked.
- R8: rsp_valid is a single-cycle pulse, and rsp_va equals the va of the request. On any fault rsp_pa is 0. A walk makes at most two reads.
- R9: mem_rd_valid is a single-cycle pulse. A request is accepted only while req_ready is 1, and req_ready is 0 in the cycle that carries a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1: descriptors shifted by 4, 36-bit addresses, permissions enforced |
| tbl_base | input | 32 | First-level table base (byte address, or frame number in wide mode) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_rd_valid | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 36 | Byte address of the descriptor |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor value |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_pa | output | 36 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 translation fault, 2 protection fault |
| rsp_va | output | 32 | Virtual address of the request being answered |

## Verification
The response of one walk and the arrival of the next request can fall in the same cycle: a client that keeps req_valid high while a result is being returned must not have its request taken until the walker is idle again. The bench provokes this by issuing requests back to back. A scoreboard then checks that each response carries its own address and result, that req_ready is low during the response, and that the held request starts its reads with the correct first-level address. The zero-wait memory case, where the acknowledge comes in the first waiting cycle, is run alongside the longer latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_XLATE = 2'd1,
      FLT_PROT  = 2'd2
   } ptw_fault_e;

   typedef enum logic [1:0] {
      DK_FAULT = 2'd0,
      DK_TABLE = 2'd1,
      DK_LEAF  = 2'd2
   } desc_kind_e;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_L1_REQ  = 3'd1,
      S_L1_WAIT = 3'd2,
      S_L2_REQ  = 3'd3,
      S_L2_WAIT = 3'd4,
      S_DONE    = 3'd5
   } walk_state_e;

   localparam int PERM_W = 2;

endpackage

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr #(
   parameter int PA_W      = 36,
   parameter int IDX_W     = 12,
   parameter int ENT_LOG2  = 2
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);
   localparam int SPAN_W = IDX_W + ENT_LOG2;

   generate
      if (SPAN_W > PA_W) begin : g_bad_span
         $error("ptw_fetch_addr: index span wider than address");
      end
   endgenerate

   logic [PA_W-1:0] offs;
   assign offs = PA_W'(idx) << ENT_LOG2;
   assign addr = base + offs;
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
   import ptw_pkg::*;
#(
   parameter int LEVEL       = 1,
   parameter int VA_W        = 32,
   parameter int PA_W        = 36,
   parameter int DESC_W      = 32,
   parameter int WIDE_SHIFT  = 4,
   parameter int SECT_OFF_W  = 20,
   parameter int LARGE_OFF_W = 16,
   parameter int PAGE_OFF_W  = 12,
   parameter int TBL_ALIGN   = 6,
   parameter int PERM_LSB    = 4
) (
   input  logic [DESC_W-1:0] desc,
   input  logic              wide,
   input  logic [VA_W-1:0]   va,
   output desc_kind_e        kind,
   output logic [PA_W-1:0]   leaf_pa,
   output logic [PERM_W-1:0] perm,
   output logic [PA_W-1:0]   next_base
);
   localparam logic [PA_W-1:0] ONE       = PA_W'(1);
   localparam logic [PA_W-1:0] SECT_LOW  = (ONE << SECT_OFF_W) - ONE;
   localparam logic [PA_W-1:0] LARGE_LOW = (ONE << LARGE_OFF_W) - ONE;
   localparam logic [PA_W-1:0] PAGE_LOW  = (ONE << PAGE_OFF_W) - ONE;
   localparam logic [PA_W-1:0] ALIGN_LOW = (ONE << TBL_ALIGN) - ONE;

   generate
      if (PERM_LSB + PERM_W > DESC_W) begin : g_bad_perm
         $error("ptw_desc_decode: permission field outside descriptor");
      end
      if (LEVEL != 1 && LEVEL != 2) begin : g_bad_level
         $error("ptw_desc_decode: LEVEL must be 1 or 2");
      end
   endgenerate

   logic [PA_W-1:0] desc_ext;
   logic [PA_W-1:0] desc_sh;
   logic [PA_W-1:0] va_ext;

   assign desc_ext = PA_W'(desc);
   assign desc_sh  = wide ? (desc_ext << WIDE_SHIFT) : desc_ext;
   assign va_ext   = PA_W'(va);
   assign perm     = desc[PERM_LSB +: PERM_W];

   generate
      if (LEVEL == 1) begin : g_first
         logic [PA_W-1:0] tbl_raw;
         assign tbl_raw = desc_ext & ~ALIGN_LOW;
         always_comb begin
            next_base = wide ? (tbl_raw << WIDE_SHIFT) : tbl_raw;
            leaf_pa   = (desc_sh & ~SECT_LOW) | (va_ext & SECT_LOW);
            case (desc[1:0])
               2'b10:   kind = DK_LEAF;
               2'b01:   kind = DK_TABLE;
               default: kind = DK_FAULT;
            endcase
         end
      end else begin : g_second
         always_comb begin
            next_base = '0;
            if (desc[1]) begin
               kind    = DK_LEAF;
               leaf_pa = (desc_sh & ~PAGE_LOW) | (va_ext & PAGE_LOW);
            end else if (desc[0]) begin
               kind    = DK_LEAF;
               leaf_pa = (desc_sh & ~LARGE_LOW) | (va_ext & LARGE_LOW);
            end else begin
               kind    = DK_FAULT;
               leaf_pa = '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
   import ptw_pkg::*;
(
   input  logic              enforce,
   input  logic [PERM_W-1:0] perm,
   input  logic              write,
   output logic              allow
);
   logic needed;
   assign needed = write ? perm[1] : perm[0];
   assign allow  = !enforce || needed;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 36,
   parameter int DESC_W      = 32,
   parameter int L1_IDX_W    = 12,
   parameter int PAGE_OFF_W  = 12,
   parameter int LARGE_OFF_W = 16,
   parameter int WIDE_SHIFT  = 4,
   parameter int BASE_SHIFT  = 12,
   parameter int TBL_ALIGN   = 6,
   parameter int L1_PERM_LSB = 4,
   parameter int L2_PERM_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [DESC_W-1:0] tbl_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_write,
   output logic              mem_rd_valid,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [DESC_W-1:0] mem_rd_data,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [1:0]        rsp_fault,
   output logic [VA_W-1:0]   rsp_va
);
   localparam int SECT_OFF_W = VA_W - L1_IDX_W;
   localparam int L2_IDX_W   = SECT_OFF_W - PAGE_OFF_W;

   generate
      if (PA_W < DESC_W + WIDE_SHIFT) begin : g_bad_pa
         $error("ptw_walker: PA_W too small for shifted descriptors");
      end
      if (!(PAGE_OFF_W < LARGE_OFF_W && LARGE_OFF_W < SECT_OFF_W)) begin : g_bad_off
         $error("ptw_walker: page, large page and section sizes out of order");
      end
      if (L2_IDX_W < 1) begin : g_bad_l2
         $error("ptw_walker: no room for a second-level index");
      end
   endgenerate

   walk_state_e         state_q;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic [PA_W-1:0]     l2_addr_q;
   logic [PA_W-1:0]     pa_q;
   ptw_fault_e          fault_q;

   // first-level table base
   logic [PA_W-1:0] root_base;
   assign root_base = wide_mode ? (PA_W'(tbl_base) << BASE_SHIFT) : PA_W'(tbl_base);

   logic [PA_W-1:0] l1_fetch;
   ptw_fetch_addr #(.PA_W(PA_W), .IDX_W(L1_IDX_W)) u_fa1 (
      .base (root_base),
      .idx  (va_q[VA_W-1 -: L1_IDX_W]),
      .addr (l1_fetch)
   );

   desc_kind_e        l1_kind, l2_kind;
   logic [PA_W-1:0]   l1_pa, l2_pa, l1_next, l2_next_unused;
   logic [PERM_W-1:0] l1_perm, l2_perm;

   ptw_desc_decode #(
      .LEVEL(1), .VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W),
      .WIDE_SHIFT(WIDE_SHIFT), .SECT_OFF_W(SECT_OFF_W),
      .LARGE_OFF_W(LARGE_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
      .TBL_ALIGN(TBL_ALIGN), .PERM_LSB(L1_PERM_LSB)
   ) u_dec1 (
      .desc(mem_rd_data), .wide(wide_mode), .va(va_q),
      .kind(l1_kind), .leaf_pa(l1_pa), .perm(l1_perm), .next_base(l1_next)
   );

   ptw_desc_decode #(
      .LEVEL(2), .VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W),
      .WIDE_SHIFT(WIDE_SHIFT), .SECT_OFF_W(SECT_OFF_W),
      .LARGE_OFF_W(LARGE_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
      .TBL_ALIGN(TBL_ALIGN), .PERM_LSB(L2_PERM_LSB)
   ) u_dec2 (
      .desc(mem_rd_data), .wide(wide_mode), .va(va_q),
      .kind(l2_kind), .leaf_pa(l2_pa), .perm(l2_perm), .next_base(l2_next_unused)
   );

   logic [PA_W-1:0] l2_fetch;
   ptw_fetch_addr #(.PA_W(PA_W), .IDX_W(L2_IDX_W)) u_fa2 (
      .base (l1_next),
      .idx  (va_q[SECT_OFF_W-1 -: L2_IDX_W]),
      .addr (l2_fetch)
   );

   logic [PERM_W-1:0] perm_sel;
   logic              allow;
   assign perm_sel = (state_q == S_L2_WAIT) ? l2_perm : l1_perm;

   ptw_perm_check u_perm (
      .enforce (wide_mode),
      .perm    (perm_sel),
      .write   (wr_q),
      .allow   (allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         l2_addr_q <= '0;
         pa_q      <= '0;
         fault_q   <= FLT_NONE;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  wr_q    <= req_write;
                  state_q <= S_L1_REQ;
               end
            end
            S_L1_REQ: state_q <= S_L1_WAIT;
            S_L1_WAIT: begin
               if (mem_rd_ack) begin
                  case (l1_kind)
                     DK_LEAF: begin
                        pa_q    <= allow ? l1_pa : '0;
                        fault_q <= allow ? FLT_NONE : FLT_PROT;
                        state_q <= S_DONE;
                     end
                     DK_TABLE: begin
                        l2_addr_q <= l2_fetch;
                        state_q   <= S_L2_REQ;
                     end
                     default: begin
                        pa_q    <= '0;
                        fault_q <= FLT_XLATE;
                        state_q <= S_DONE;
                     end
                  endcase
               end
            end
            S_L2_REQ: state_q <= S_L2_WAIT;
            S_L2_WAIT: begin
               if (mem_rd_ack) begin
                  if (l2_kind == DK_LEAF) begin
                     pa_q    <= allow ? l2_pa : '0;
                     fault_q <= allow ? FLT_NONE : FLT_PROT;
                  end else begin
                     pa_q    <= '0;
                     fault_q <= FLT_XLATE;
                  end
                  state_q <= S_DONE;
               end
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == S_IDLE);
   assign mem_rd_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
   assign mem_rd_addr  = (state_q == S_L2_REQ) ? l2_addr_q : l1_fetch;
   assign rsp_valid    = (state_q == S_DONE);
   assign rsp_pa       = pa_q;
   assign rsp_fault    = fault_q;
   assign rsp_va       = va_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 36,
   parameter int DESC_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide_mode,
   input logic [DESC_W-1:0] tbl_base,
   input logic              req_valid,
   input logic              req_ready,
   input logic [VA_W-1:0]   req_va,
   input logic              req_write,
   input logic              mem_rd_valid,
   input logic [PA_W-1:0]   mem_rd_addr,
   input logic              mem_rd_ack,
   input logic [DESC_W-1:0] mem_rd_data,
   input logic              rsp_valid,
   input logic [PA_W-1:0]   rsp_pa,
   input logic [1:0]        rsp_fault,
   input logic [VA_W-1:0]   rsp_va
);
   logic [1:0] reads_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reads_seen <= '0;
      else if (req_valid && req_ready)
         reads_seen <= '0;
      else if (mem_rd_valid && reads_seen != 2'd3)
         reads_seen <= reads_seen + 2'd1;
   end

   p_read_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> reads_seen < 2'd2)
      else $error("walk issued more than two reads");

   p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid)
      else $error("response longer than one cycle");

   p_fault_zero_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> rsp_pa == '0)
      else $error("faulting response carries an address");

   p_va_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(rsp_va))
      else $error("reported va changed during a walk");

   p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid)
      else $error("read strobe longer than one cycle");

   p_busy_on_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready)
      else $error("ready during response");

   p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_fault != 2'd3)
      else $error("undefined fault code");

   p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00)
      else $error("descriptor read not word aligned");
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W)) u_chk (.*);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        mem_rd_valid;
   logic [35:0] mem_rd_addr;
   logic        mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        rsp_valid;
   logic [35:0] rsp_pa;
   logic [1:0]  rsp_fault;
   logic [31:0] rsp_va;

   always #5 clk = ~clk;

   ptw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .tbl_base(tbl_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_va(rsp_va)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [35:0] pa;
      logic [1:0]  flt;
      logic [1:0]  nrd;
      logic [35:0] a0;
      logic [35:0] a1;
   } exp_t;

   exp_t        exp_q[$];
   string       tag_q[$];
   logic [35:0] rd_log[$];
   logic [31:0] mem_model [logic [35:0]];
   int          checks = 0;
   int          errors = 0;
   int          mem_lat = 0;
   bit          done_flag = 1'b0;

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_mem(logic [35:0] a);
      if (mem_model.exists(a)) return mem_model[a];
      return 32'h0;
   endfunction

   function automatic logic [35:0] root_of();
      logic [35:0] b;
      b = {4'h0, tbl_base};
      return wide_mode ? (b << 12) : b;
   endfunction

   function automatic void put_l1(logic [31:0] va, logic [31:0] d);
      mem_model[root_of() + {22'h0, va[31:20], 2'b00}] = d;
   endfunction

   function automatic void put_l2(logic [31:0] l1d, logic [31:0] va, logic [31:0] d);
      logic [35:0] tb;
      tb = {4'h0, l1d & 32'hFFFF_FFC0};
      if (wide_mode) tb = tb << 4;
      mem_model[tb + {26'h0, va[19:12], 2'b00}] = d;
   endfunction

   function automatic logic perm_ok(logic [1:0] p, logic wr);
      if (!wide_mode) return 1'b1;
      return wr ? p[1] : p[0];
   endfunction

   // reference model of the walk, built from the requirements
   function automatic exp_t ref_walk(logic [31:0] va, logic wr);
      exp_t e;
      logic [31:0] d1, d2;
      logic [35:0] sd, tb;
      int s;
      s = wide_mode ? 4 : 0;
      e = '0;
      e.va = va;
      e.a0 = root_of() + {22'h0, va[31:20], 2'b00};
      e.nrd = 2'd1;
      d1 = rd_mem(e.a0);
      sd = {4'h0, d1} << s;
      if (d1[1:0] == 2'b10) begin
         if (perm_ok(d1[5:4], wr)) e.pa = {sd[35:20], va[19:0]};
         else e.flt = 2'd2;
      end else if (d1[1:0] == 2'b01) begin
         tb = {4'h0, d1 & 32'hFFFF_FFC0} << s;
         e.a1 = tb + {26'h0, va[19:12], 2'b00};
         e.nrd = 2'd2;
         d2 = rd_mem(e.a1);
         sd = {4'h0, d2} << s;
         if (d2[1]) begin
            if (perm_ok(d2[3:2], wr)) e.pa = {sd[35:12], va[11:0]};
            else e.flt = 2'd2;
         end else if (d2[0]) begin
            if (perm_ok(d2[3:2], wr)) e.pa = {sd[35:16], va[15:0]};
            else e.flt = 2'd2;
         end else e.flt = 2'd1;
      end else e.flt = 2'd1;
      return e;
   endfunction

   // driver: push expectation, then present the request until taken
   task automatic do_walk(logic [31:0] va, logic wr, string tag);
      exp_q.push_back(ref_walk(va, wr));
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_va    = va;
      req_write = wr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // memory responder
   initial begin
      logic [35:0] a;
      @(negedge clk);
      forever begin
         if (mem_rd_valid) begin
            a = mem_rd_addr;
            repeat (mem_lat + 1) @(negedge clk);
            mem_rd_ack  = 1'b1;
            mem_rd_data = rd_mem(a);
            @(negedge clk);
            mem_rd_ack  = 1'b0;
            mem_rd_data = 32'h0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // monitor / scoreboard
   initial begin
      exp_t  e;
      string t;
      forever begin
         @(negedge clk);
         if (rst_n && mem_rd_valid) rd_log.push_back(mem_rd_addr);
         if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
               check("R8", "unexpected response", 64'h1, 64'h0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check("R8", "rsp_va", {32'h0, rsp_va}, {32'h0, e.va});
               check(t, "rsp_pa", {28'h0, rsp_pa}, {28'h0, e.pa});
               check(t, "rsp_fault", {62'h0, rsp_fault}, {62'h0, e.flt});
               check("R9", "req_ready during response", {63'h0, req_ready}, 64'h0);
               check("R8", "read count", 64'(rd_log.size()), {62'h0, e.nrd});
               if (rd_log.size() >= 1)
                  check("R2", "first read address", {28'h0, rd_log[0]}, {28'h0, e.a0});
               if (rd_log.size() >= 2 && e.nrd == 2'd2)
                  check("R4", "second read address", {28'h0, rd_log[1]}, {28'h0, e.a1});
            end
            rd_log.delete();
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "req_ready in reset", {63'h0, req_ready}, 64'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "req_ready after reset", {63'h0, req_ready}, 64'h1);
      check("R1", "rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
      check("R1", "mem_rd_valid after reset", {63'h0, mem_rd_valid}, 64'h0);

      // ---------------- narrow mode ----------------
      wide_mode = 1'b0;
      tbl_base  = 32'h0010_0000;
      put_l1(32'h0030_0000, 32'h8000_0002);
      put_l1(32'h0050_0000, 32'h0004_0401);
      put_l2(32'h0004_0401, 32'h0051_2000, 32'h1234_5002);
      put_l2(32'h0004_0401, 32'h0053_7000, 32'h7654_0001);
      put_l1(32'h0070_0000, 32'h0000_0003);
      put_l1(32'h00A0_0000, 32'h0300_0032);

      mem_lat = 0;
      do_walk(32'h0030_1234, 1'b0, "R3");
      do_walk(32'h0030_ABCD, 1'b1, "R3");
      do_walk(32'h0051_2ABC, 1'b0, "R6");
      do_walk(32'h0053_7DEF, 1'b1, "R6");
      drain();
      mem_lat = 2;
      do_walk(32'h0054_0000, 1'b0, "R6");
      do_walk(32'h0070_0000, 1'b0, "R5");
      do_walk(32'h0090_0010, 1'b1, "R5");
      // perm field 3 but also perm 0 case: no check in narrow mode
      put_l1(32'h00B0_0000, 32'h0300_0002);
      do_walk(32'h00B0_0040, 1'b1, "R7");
      drain();

      // ---------------- wide mode ----------------
      wide_mode = 1'b1;
      tbl_base  = 32'h0000_0300;
      put_l1(32'h1230_0000, 32'hA000_0032);
      put_l1(32'h1240_0000, 32'h0100_0012);
      put_l1(32'h1250_0000, 32'h0200_0022);
      put_l1(32'h1260_0000, 32'h0300_0002);
      put_l1(32'h1270_0000, 32'h0000_5041);
      put_l2(32'h0000_5041, 32'h1271_2000, 32'hFEDC_B00E);
      put_l2(32'h0000_5041, 32'h1272_0000, 32'h1111_1007);
      put_l2(32'h0000_5041, 32'h1273_8000, 32'h2222_2009);
      put_l1(32'h1280_0000, 32'h0000_0000);

      mem_lat = 1;
      do_walk(32'h1230_0456, 1'b0, "R3");
      do_walk(32'h1230_0456, 1'b1, "R3");
      do_walk(32'h1240_1000, 1'b0, "R7");
      do_walk(32'h1240_1000, 1'b1, "R7");
      do_walk(32'h1250_2000, 1'b0, "R7");
      do_walk(32'h1250_2000, 1'b1, "R7");
      do_walk(32'h1260_0000, 1'b0, "R7");
      drain();
      mem_lat = 3;
      do_walk(32'h1271_2345, 1'b0, "R6");
      do_walk(32'h1272_0FFF, 1'b0, "R6");
      do_walk(32'h1272_0FFF, 1'b1, "R7");
      do_walk(32'h1273_89AB, 1'b1, "R6");
      do_walk(32'h1273_89AB, 1'b0, "R7");
      do_walk(32'h1279_0000, 1'b0, "R6");
      do_walk(32'h1280_0000, 1'b1, "R5");
      drain();

      // back-to-back requests with zero-wait memory (R9 overlap)
      mem_lat = 0;
      do_walk(32'h1271_2FFF, 1'b1, "R9");
      do_walk(32'h1230_FFFF, 1'b1, "R9");
      do_walk(32'h1260_0000, 1'b1, "R9");
      drain();
      check("R9", "idle after overlap", {63'h0, req_ready}, 64'h1);

      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule